// File: doc/BRIEF.md
# Per-Domain Self-Clearing Reset Controller

This block lets software reset any of eight digital sub-domains on its own, without a full chip reset. It is meant for recovery and debug. A control register holds one active-low bit per domain. Writing a 0 to a bit starts that domain's reset, and the bit returns to 1 by itself as soon as the operation is launched. A second, read-only status register holds one bit per domain. A status bit reads 0 while that domain's reset is outstanding and returns to 1 once the reset has really happened. Software polls it until it reads all ones.

Each domain runs from a clock that may be stopped, which the block sees as a clock-enable input. The request reaches the domain through a synchronizer that advances only while that domain's clock runs. The domain then holds its reset output for a minimum number of its own clock cycles, and an acknowledge returns to the register side through a second synchronizer. If a domain's clock is stopped, its reset stays pending and completes after the clock resumes. The global reset clears the control register to all zeros, so every domain is reset once after power-up.

Top module: `rstc_top`

## Requirements
- R1: While `rst_n` is low, the control register reads 0x00, the status register reads 0x00 and no `dom_rst` is high. After release, every domain is reset exactly once and the status register then reads 0xFF.
- R2: A write to the control address (0x10) with bit i at 0 starts a reset of domain i. Bits written as 1 start nothing.
- R3: A control bit written as 0 reads 0 in the cycle after the write and reads 1 one cycle later, without any further write.
- R4: Status bit i reads 0 from the cycle after a write requesting domain i. It stays 0 until that domain's reset has completed, and then returns to 1.
- R5: Each assertion of `dom_rst[i]` covers at least HOLD_CYC (2) rising clock edges on which `dom_clk_en[i]` is high.
- R6: While `dom_clk_en[i]` is low, `dom_rst[i]` does not change and a pending reset of domain i does not complete. The reset completes after the enable returns high.
- R7: A new request for a domain whose reset is still running is not lost. The domain is reset a second time, and status bit i returns to 1 only after that second reset.
- R8: Writes to the status address (0x11) or to any other address that is not the control address change nothing.
- R9: A read of the status address returns the status vector, a read of the control address returns the control register, and a read of any other address returns 0.
- R10: A request for one set of domains leaves `dom_rst` low and the status bits at 1 for all other domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-side clock; domain clocks are this clock gated by their enables |
| rst_n | input | 1 | Asynchronous active-low global reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data, one bit per domain |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational read data |
| dom_clk_en | input | 8 | Per-domain clock-running indication |
| dom_rst | output | 8 | Per-domain reset, active high |

## Verification
The assertions take the global reset to be held low across at least one clock edge. They treat the domain enables as arbitrary levels, so the frozen-output and full-pulse properties must hold even when an enable drops in the middle of a handshake. The stimulus drives every write, read and enable change on the falling clock edge, keeps each write to a single cycle, and changes an enable only between clock edges. It stops one domain's clock before a request and restarts it later, and it issues a second request while the first handshake is still in flight, so both the stall path and the relaunch path are reached.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_DONE
   } rstc_sel_e;

   localparam int unsigned RSTC_MIN_HOLD = 2;
   localparam int unsigned RSTC_MIN_SYNC = 2;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic d,
   output logic q
);
   if (STAGES < rstc_pkg::RSTC_MIN_SYNC) begin : g_bad
      $error("rstc_sync: STAGES below minimum");
   end

   if (STAGES == 2) begin : g_two
      logic s1_q, s2_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
         end else if (en) begin
            s1_q <= d;
            s2_q <= s1_q;
         end
      end
      assign q = s2_q;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else if (en) sh_q <= {sh_q[STAGES-2:0], d};
      end
      assign q = sh_q[STAGES-1];
   end
endmodule

// File: rtl/rstc_launch.sv
module rstc_launch #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ack_raw,
   output logic req_o,
   output logic idle_o
);
   logic ack_s, req_q, again_q, busy, launch;

   rstc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (1'b1),
      .d     (ack_raw),
      .q     (ack_s)
   );

   assign busy   = req_q | ack_s;
   assign launch = !busy && (start || again_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         again_q <= 1'b0;
      end else begin
         if (req_q && ack_s) req_q <= 1'b0;
         else if (launch)    req_q <= 1'b1;
         if (launch)              again_q <= 1'b0;
         else if (start && busy)  again_q <= 1'b1;
      end
   end

   assign req_o  = req_q;
   assign idle_o = !busy && !again_q;

   // R7: a remembered request is launched once the handshake is quiet
   p_relaunch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (again_q && !req_q && !ack_s) |=> req_q);

   // R4: a start is never idle in the following cycle
   p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !idle_o);
endmodule

// File: rtl/rstc_domain.sv
module rstc_domain #(
   parameter int unsigned HOLD_CYC    = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic req_raw,
   output logic ack_o,
   output logic rst_o
);
   localparam int unsigned CW = $clog2(HOLD_CYC + 1);

   logic          req_s, ack_q;
   logic [CW-1:0] cnt_q;

   rstc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .d     (req_raw),
      .q     (req_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ack_q <= 1'b0;
      end else if (en) begin
         if (!req_s) begin
            cnt_q <= '0;
            ack_q <= 1'b0;
         end else if (!ack_q) begin
            if (cnt_q == CW'(HOLD_CYC - 1)) ack_q <= 1'b1;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign rst_o = req_s | ack_q;
   assign ack_o = ack_q;

   // R6: a stopped domain clock freezes the reset output
   p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(rst_o));

   // R5: the reset output only falls after the hold count was acknowledged
   p_full_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_o) |-> $past(ack_q));
endmodule

// File: rtl/rstc_top.sv
module rstc_top
   import rstc_pkg::*;
#(
   parameter int unsigned     N_DOM       = 8,
   parameter int unsigned     ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h10,
   parameter logic [ADDR_W-1:0] DONE_ADDR = 'h11,
   parameter int unsigned     HOLD_CYC    = 2,
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [N_DOM-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [N_DOM-1:0]  rd_data,
   input  logic [N_DOM-1:0]  dom_clk_en,
   output logic [N_DOM-1:0]  dom_rst
);
   if (HOLD_CYC < RSTC_MIN_HOLD) begin : g_bad_hold
      $error("rstc_top: HOLD_CYC below minimum");
   end
   if (CTRL_ADDR == DONE_ADDR) begin : g_bad_addr
      $error("rstc_top: control and status addresses collide");
   end

   logic [N_DOM-1:0] ctrl_q, start, req, idle, ack_raw, done;
   logic             wr_ctrl;
   rstc_sel_e        rd_sel;

   assign wr_ctrl = wr_en && (wr_addr == CTRL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wr_data;
      else              ctrl_q <= '1;
   end

   assign start = ~ctrl_q;
   assign done  = ctrl_q & idle;

   always_comb begin
      if (rd_addr == CTRL_ADDR)      rd_sel = SEL_CTRL;
      else if (rd_addr == DONE_ADDR) rd_sel = SEL_DONE;
      else                           rd_sel = SEL_NONE;
      case (rd_sel)
         SEL_CTRL: rd_data = ctrl_q;
         SEL_DONE: rd_data = done;
         default:  rd_data = '0;
      endcase
   end

   for (genvar i = 0; i < N_DOM; i++) begin : g_dom
      rstc_launch #(.SYNC_STAGES(SYNC_STAGES)) u_launch (
         .clk     (clk),
         .rst_n   (rst_n),
         .start   (start[i]),
         .ack_raw (ack_raw[i]),
         .req_o   (req[i]),
         .idle_o  (idle[i])
      );

      rstc_domain #(.HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)) u_dom (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (dom_clk_en[i]),
         .req_raw (req[i]),
         .ack_o   (ack_raw[i]),
         .rst_o   (dom_rst[i])
      );

      // R4: a zero written to a bit clears its status bit next cycle
      p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_ctrl && !wr_data[i]) |=> !done[i]);

      // R3: a cleared control bit sets itself unless written to zero again
      p_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!ctrl_q[i] && !(wr_ctrl && !wr_data[i])) |=> ctrl_q[i]);
   end
endmodule

// File: tb/tb_rstc_top.sv
`timescale 1ns/1ps
module tb_rstc_top;
   localparam logic [7:0] CA = 8'h10;
   localparam logic [7:0] DA = 8'h11;
   localparam int NV = 8;
   // {address, data, expected reset mask}
   localparam logic [23:0] VEC [NV] = '{
      {CA, 8'hFE, 8'h01}, {CA, 8'h7F, 8'h80}, {CA, 8'h00, 8'hFF},
      {CA, 8'hFF, 8'h00}, {DA, 8'h00, 8'h00}, {8'h33, 8'h00, 8'h00},
      {CA, 8'hA5, 8'h5A}, {CA, 8'hF0, 8'h0F}
   };

   logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;
   logic [7:0] dom_clk_en = 8'hFF, dom_rst;
   int total = 0, bad = 0;
   int rises [8];
   int lens [8];
   bit short_p [8];
   logic [7:0] prv = '0;

   always #10 clk = ~clk;

   rstc_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .dom_clk_en(dom_clk_en), .dom_rst(dom_rst)
   );

   always @(posedge clk) begin
      for (int i = 0; i < 8; i++) begin
         if (dom_rst[i] && !prv[i]) rises[i]++;
         if (dom_rst[i] && dom_clk_en[i]) lens[i]++;
         if (!dom_rst[i] && prv[i]) begin
            if (lens[i] < 2) short_p[i] = 1'b1;
            lens[i] = 0;
         end
      end
      prv = dom_rst;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      for (int i = 0; i < 8; i++) begin
         rises[i] = 0; short_p[i] = 1'b0;
      end
   endtask

   function automatic logic [7:0] rise_mask(input int n);
      logic [7:0] m = '0;
      for (int i = 0; i < 8; i++) m[i] = (rises[i] == n);
      return m;
   endfunction

   function automatic logic [7:0] short_mask();
      logic [7:0] m = '0;
      for (int i = 0; i < 8; i++) m[i] = short_p[i];
      return m;
   endfunction

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      logic [7:0] v;
      ok = 1'b0;
      for (int k = 0; k < 300; k++) begin
         rd(DA, v);
         if (v == 8'hFF) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      bit ok;
      clear_mon();
      // R1: reset state
      repeat (3) @(negedge clk);
      rd(CA, v); check(v == 8'h00, "R1 ctrl in reset", v, 8'h00);
      rd(DA, v); check(v == 8'h00, "R1 done in reset", v, 8'h00);
      check(dom_rst == 8'h00, "R1 no reset out in reset", dom_rst, 8'h00);
      rst_n = 1'b1;
      wait_done(ok);
      check(ok, "R1 completion after release", ok, 1);
      check(rise_mask(1) == 8'hFF, "R1 one reset per domain", rise_mask(1), 8'hFF);

      // table-driven writes: R2 R3 R4 R5 R8 R10
      foreach (VEC[n]) begin
         logic [7:0] a, d, m;
         {a, d, m} = VEC[n];
         @(negedge clk); clear_mon();
         wr(a, d);
         rd(DA, v); check(v == ~m, "R4 done drops for requested", v, ~m);
         rd(CA, v); check(v == ((a == CA) ? d : 8'hFF), "R3 written zero visible", v, (a == CA) ? d : 8'hFF);
         @(negedge clk);
         rd(CA, v); check(v == 8'hFF, "R3 self-cleared", v, 8'hFF);
         wait_done(ok);
         check(ok, "R4 done returns", ok, 1);
         check(rise_mask(1) == m && rise_mask(0) == ~m, "R2 R8 R10 reset set", rise_mask(1), m);
         check(short_mask() == 8'h00, "R5 pulse length", short_mask(), 0);
      end

      // R9: read of unmapped address
      rd(8'h42, v); check(v == 8'h00, "R9 unmapped read", v, 0);

      // R6: stopped clock stalls domain 2
      @(negedge clk); clear_mon();
      dom_clk_en = 8'hFB;
      wr(CA, 8'hFB);
      repeat (40) @(negedge clk);
      rd(DA, v); check(v == 8'hFB, "R6 stalled done", v, 8'hFB);
      check(dom_rst[2] == 1'b0 && rises[2] == 0, "R6 no reset while stopped", rises[2], 0);
      dom_clk_en = 8'hFF;
      wait_done(ok);
      check(ok && rises[2] == 1, "R6 completes after restart", rises[2], 1);

      // R7: second request while busy
      @(negedge clk); clear_mon();
      wr(CA, 8'hFE);
      repeat (4) @(negedge clk);
      wr(CA, 8'hFE);
      wait_done(ok);
      check(ok, "R7 completion", ok, 1);
      check(rises[0] == 2, "R7 second reset not lost", rises[0], 2);
      check(short_mask() == 8'h00, "R5 pulse length after extend", short_mask(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule